// File: doc/BRIEF.md
# Parameterised Register-Mapped GPIO Port

This block is a general-purpose I/O port that hangs off a simple synchronous register bus. The port has one pin for each bit of its register width, which may be 8, 16, 32 or 64 bits. Each pin has an output value, an output enable and an input sample. Software sees four word registers: a data register, a set register, a clear register and a direction register.

Three parameters are fixed when the block is built. The first is the output write model: plain (the data register holds the output image), set/clear (separate registers raise and lower individual bits) or set-only (one register carries the whole output image and the data register is read-only). The second is the direction model: none (every pin is always driven and always sampled), high-means-output, or high-means-input. The third is the lane ordering: register bits can be mirrored so that pin n sits at bit WIDTH-1-n, and the bus view can be byte-swapped.

Pin inputs pass through a two-stage synchroniser. Register reads return their data one clock after the read strobe, and the read data holds between reads.

Top module: `gpio_mmio_port`

## Requirements
- R1: In plain mode a write to address 0 (data) replaces the output image, and writes to addresses 1 (set) and 2 (clear) change nothing, while a read of address 1 returns zero.
- R2: A read of address 0 returns the synchronised pin inputs. A pin change made before clock edge k is returned by a read strobe sampled at edge k+2, and not by one sampled at edge k+1.
- R3: In set/clear mode, each 1 bit written to address 1 drives its pin high and each 1 bit written to address 2 drives its pin low. Zero bits, and writes to address 0, leave the pins unchanged.
- R4: In set/clear and set-only modes a read of address 1 returns the current output image. A read of address 2 returns zero in every mode.
- R5: In set-only mode a write to address 1 replaces the whole output image (1 high, 0 low). Writes to addresses 0 and 2 change nothing.
- R6: In high-means-output mode a 1 written at address 3 (direction) enables the pin's driver and a 0 disables it. The register reads back as written.
- R7: In high-means-input mode a 1 at address 3 disables the driver and a 0 enables it, so after reset the direction register reads all ones.
- R8: With no direction model every output enable is 1 at all times, writes to address 3 are ignored, and address 3 reads zero.
- R9: With mirrored ordering, pin n corresponds to register bit WIDTH-1-n in every register, for both reads and writes.
- R10: With byte swapping, register byte b appears in bus byte NBYTES-1-b for both reads and writes. Byte swapping with a 64-bit width is rejected when the block is built, as is any width other than 8, 16, 32 or 64.
- R11: After synchronous reset, every output value is 0, every output enable is 0 (except with no direction model), and the read data is 0.
- R12: The read data changes only at a clock edge where the read strobe is high, and it then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word address: 0 data, 1 set, 2 clear, 3 direction |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data, bus byte order |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | WIDTH | Read data, valid the cycle after the strobe |
| pin_in | input | WIDTH | Asynchronous pin samples |
| pin_out | output | WIDTH | Pin output values |
| pin_oe | output | WIDTH | Pin output enables |

## Verification
The hardest point to reach from the ports is the exact boundary of input latency. A read issued one edge too early must still return the old pin state, so the stimulus changes the pins half a cycle before an edge and holds a read strobe across the two following edges, comparing both results. The three build variants are run side by side on one shared bus. Any write then tests one instance's effect and the other two instances' immunity to that same write, over a sweep of mixed bit patterns that covers every lane of mirroring and byte swapping.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

  // output write models
  localparam int WR_PLAIN   = 0;
  localparam int WR_SETCLR  = 1;
  localparam int WR_SETONLY = 2;

  // direction register polarity
  localparam int DIR_NONE   = 0;
  localparam int DIR_OUT_HI = 1;
  localparam int DIR_IN_HI  = 2;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_DATA = 2'd0,
    RA_SET  = 2'd1,
    RA_CLR  = 2'd2,
    RA_DIR  = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/gpio_lane_map.sv
// Permutes a word between bus order and pin order: optional byte swap,
// then optional bit mirror. Both steps are involutions and commute, so the
// same module serves both directions.
module gpio_lane_map #(
  parameter int WIDTH     = 32,
  parameter bit BIT_REV   = 1'b0,
  parameter bit BYTE_SWAP = 1'b0
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int NBYTES = WIDTH / 8;

  logic [WIDTH-1:0] swapped;

  generate
    if (BYTE_SWAP) begin : g_swap
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign swapped[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
      end
    end else begin : g_noswap
      assign swapped = din;
    end

    if (BIT_REV) begin : g_rev
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign dout[i] = swapped[WIDTH-1-i];
      end
    end else begin : g_norev
      assign dout = swapped;
    end
  endgenerate

endmodule

// File: rtl/gpio_in_sync.sv
// Multi-stage input synchroniser for the pin samples.
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_regs.sv
// Output image and output-enable state, in pin order.
module gpio_pin_regs
  import gpio_cfg_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int WR_STYLE  = WR_PLAIN,
  parameter int DIR_STYLE = DIR_OUT_HI
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_data,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic             wr_dir,
  input  logic [WIDTH-1:0] wvalue,
  output logic [WIDTH-1:0] img_q,
  output logic [WIDTH-1:0] oe_q
);

  generate
    if (WR_STYLE == WR_SETCLR) begin : g_setclr
      always_ff @(posedge clk) begin
        if (rst)         img_q <= '0;
        else if (wr_set) img_q <= img_q | wvalue;
        else if (wr_clr) img_q <= img_q & ~wvalue;
      end
    end else if (WR_STYLE == WR_SETONLY) begin : g_setonly
      always_ff @(posedge clk) begin
        if (rst)         img_q <= '0;
        else if (wr_set) img_q <= wvalue;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)          img_q <= '0;
        else if (wr_data) img_q <= wvalue;
      end
    end

    if (DIR_STYLE == DIR_OUT_HI) begin : g_dir_out
      always_ff @(posedge clk) begin
        if (rst)         oe_q <= '0;
        else if (wr_dir) oe_q <= wvalue;
      end
    end else if (DIR_STYLE == DIR_IN_HI) begin : g_dir_in
      always_ff @(posedge clk) begin
        if (rst)         oe_q <= '0;
        else if (wr_dir) oe_q <= ~wvalue;
      end
    end else begin : g_dir_none
      always_ff @(posedge clk) begin
        oe_q <= '1;
      end
    end
  endgenerate

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
    (WR_STYLE == WR_SETCLR && wr_set) |=> ((img_q & $past(wvalue)) == $past(wvalue))); // R3

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (WR_STYLE == WR_SETCLR && wr_clr && !wr_set) |=> ((img_q & $past(wvalue)) == '0)); // R3

  AST_IMG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_data && !wr_set && !wr_clr) |=> $stable(img_q)); // R1

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_dir && DIR_STYLE != DIR_NONE) |=> $stable(oe_q)); // R6

  AST_OE_INV: assert property (@(posedge clk) disable iff (rst)
    (DIR_STYLE == DIR_IN_HI && wr_dir) |=> (oe_q == ~$past(wvalue))); // R7

endmodule

// File: rtl/gpio_mmio_port.sv
module gpio_mmio_port
  import gpio_cfg_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int WR_STYLE  = WR_SETCLR,
  parameter int DIR_STYLE = DIR_OUT_HI,
  parameter bit BIT_REV   = 1'b0,
  parameter bit BYTE_SWAP = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);

  generate
    if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
      $error("gpio_mmio_port: WIDTH must be 8, 16, 32 or 64");
    end
    if (BYTE_SWAP && WIDTH == 64) begin : g_bad_swap
      $error("gpio_mmio_port: byte swap is not allowed with a 64-bit width");
    end
  endgenerate

  logic [WIDTH-1:0] wvalue_pin;
  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] img_q;
  logic [WIDTH-1:0] oe_q;
  logic [WIDTH-1:0] rd_pin;
  logic [WIDTH-1:0] rd_bus;
  logic             wr_data, wr_set, wr_clr, wr_dir;

  gpio_lane_map #(.WIDTH(WIDTH), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) u_wmap (
    .din  (bus_wdata),
    .dout (wvalue_pin)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (sync_q)
  );

  always_comb begin
    wr_data = bus_wr && (bus_addr == RA_DATA) && (WR_STYLE == WR_PLAIN);
    wr_set  = bus_wr && (bus_addr == RA_SET)  && (WR_STYLE != WR_PLAIN);
    wr_clr  = bus_wr && (bus_addr == RA_CLR)  && (WR_STYLE == WR_SETCLR);
    wr_dir  = bus_wr && (bus_addr == RA_DIR)  && (DIR_STYLE != DIR_NONE);
  end

  gpio_pin_regs #(.WIDTH(WIDTH), .WR_STYLE(WR_STYLE), .DIR_STYLE(DIR_STYLE)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_data (wr_data),
    .wr_set  (wr_set),
    .wr_clr  (wr_clr),
    .wr_dir  (wr_dir),
    .wvalue  (wvalue_pin),
    .img_q   (img_q),
    .oe_q    (oe_q)
  );

  always_comb begin
    rd_pin = '0;
    case (bus_addr)
      RA_DATA: rd_pin = sync_q;
      RA_SET:  rd_pin = (WR_STYLE != WR_PLAIN) ? img_q : '0;
      RA_CLR:  rd_pin = '0;
      RA_DIR: begin
        if (DIR_STYLE == DIR_OUT_HI)     rd_pin = oe_q;
        else if (DIR_STYLE == DIR_IN_HI) rd_pin = ~oe_q;
        else                             rd_pin = '0;
      end
      default: rd_pin = '0;
    endcase
  end

  gpio_lane_map #(.WIDTH(WIDTH), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) u_rmap (
    .din  (rd_pin),
    .dout (rd_bus)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_bus;
  end

  assign pin_out = img_q;
  assign pin_oe  = oe_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R12

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == RA_CLR) |=> (bus_rdata == '0)); // R4

  AST_NONE_ALL_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (DIR_STYLE == DIR_NONE) |=> (pin_oe == '1)); // R8

endmodule

// File: tb/gpio_mmio_port_tb.sv
`timescale 1ns/1ps
module gpio_mmio_port_tb;
  import gpio_cfg_pkg::*;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   addr = 2'd0;
  logic         wr = 1'b0;
  logic         rd = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] pins = '0;

  logic [W-1:0] a_rdata, a_out, a_oe;
  logic [W-1:0] b_rdata, b_out, b_oe;
  logic [W-1:0] c_rdata, c_out, c_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // A: set/clear, high-means-output, natural ordering
  gpio_mmio_port #(.WIDTH(W), .WR_STYLE(WR_SETCLR), .DIR_STYLE(DIR_OUT_HI),
                   .BIT_REV(1'b0), .BYTE_SWAP(1'b0)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(a_rdata), .pin_in(pins), .pin_out(a_out), .pin_oe(a_oe));

  // B: plain, high-means-input, mirrored bits
  gpio_mmio_port #(.WIDTH(W), .WR_STYLE(WR_PLAIN), .DIR_STYLE(DIR_IN_HI),
                   .BIT_REV(1'b1), .BYTE_SWAP(1'b0)) u_dut_plain (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(b_rdata), .pin_in(pins), .pin_out(b_out), .pin_oe(b_oe));

  // C: set-only, no direction register, byte-swapped
  gpio_mmio_port #(.WIDTH(W), .WR_STYLE(WR_SETONLY), .DIR_STYLE(DIR_NONE),
                   .BIT_REV(1'b0), .BYTE_SWAP(1'b1)) u_dut_so (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(c_rdata), .pin_in(pins), .pin_out(c_out), .pin_oe(c_oe));

  function automatic logic [W-1:0] mirror(input logic [W-1:0] x);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = x[W-1-i];
    return r;
  endfunction

  function automatic logic [W-1:0] bswap(input logic [W-1:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // start and end at a falling edge
  task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a);
    addr = a; rd = 1'b1;
    @(posedge clk); @(negedge clk);
    rd = 1'b0;
  endtask

  logic [W-1:0] a_img, b_img, c_img, a_oe_m, b_oe_m;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    a_img = '0; b_img = '0; c_img = '0; a_oe_m = '0; b_oe_m = '0;

    check("R11 A out", a_out, '0);
    check("R11 A oe", a_oe, '0);
    check("R11 B out", b_out, '0);
    check("R11 B oe", b_oe, '0);
    check("R11 C out", c_out, '0);
    check("R8 C oe after reset", c_oe, 16'hFFFF);
    check("R11 A rdata", a_rdata, '0);

    bus_read(RA_DIR);
    check("R6 A dir reset", a_rdata, '0);
    check("R7 B dir reads ones", b_rdata, 16'hFFFF);
    check("R8 C dir reads zero", c_rdata, '0);

    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] v, w, u, d;
      v = W'(i * 40503 + 7) ^ (W'(1) << (i % W));
      w = W'(i * 9973 + 3) | (W'(1) << ((i + 5) % W));
      u = W'(i * 2719) ^ 16'h5A0F;
      d = W'(i * 31337 + 1) ^ (W'(1) << ((i * 3) % W));

      bus_write(RA_SET, v);
      a_img = a_img | v;
      c_img = bswap(v);
      check("R3 A set", a_out, a_img);
      check("R1 B ignores set", b_out, b_img);
      check("R5 R10 C set-only image", c_out, c_img);

      bus_read(RA_SET);
      check("R4 A set reads image", a_rdata, a_img);
      check("R1 B set reads zero", b_rdata, '0);
      check("R4 R10 C set readback", c_rdata, bswap(c_img));

      bus_write(RA_CLR, w);
      a_img = a_img & ~w;
      check("R3 A clear", a_out, a_img);
      check("R1 B ignores clear", b_out, b_img);
      check("R5 C ignores clear", c_out, c_img);

      bus_read(RA_CLR);
      check("R4 A clr reads zero", a_rdata, '0);
      check("R4 B clr reads zero", b_rdata, '0);
      check("R4 C clr reads zero", c_rdata, '0);

      bus_write(RA_DATA, u);
      b_img = mirror(u);
      check("R3 A ignores data", a_out, a_img);
      check("R1 R9 B data write", b_out, b_img);
      check("R5 C ignores data", c_out, c_img);

      bus_write(RA_DIR, d);
      a_oe_m = d;
      b_oe_m = ~mirror(d);
      check("R6 A oe", a_oe, a_oe_m);
      check("R7 R9 B oe", b_oe, b_oe_m);
      check("R8 C oe", c_oe, 16'hFFFF);

      bus_read(RA_DIR);
      check("R6 A dir readback", a_rdata, d);
      check("R7 B dir readback", b_rdata, d);
      check("R8 C dir reads zero", c_rdata, '0);
    end

    // input latency boundary
    for (int j = 0; j < 8; j++) begin
      logic [W-1:0] oldp, p;
      oldp = pins;
      p = W'(j * 12345 + 77) ^ (W'(1) << (j * 2));
      pins = p;                       // change before edge k
      @(posedge clk); @(negedge clk); // edge k
      addr = RA_DATA; rd = 1'b1;
      @(posedge clk); @(negedge clk); // edge k+1
      check("R2 A early read old", a_rdata, oldp);
      check("R2 R9 B early read old", b_rdata, mirror(oldp));
      @(posedge clk); @(negedge clk); // edge k+2
      rd = 1'b0;
      check("R2 A read new", a_rdata, p);
      check("R2 R9 B read new", b_rdata, mirror(p));
      check("R2 R10 C read new", c_rdata, bswap(p));
      pins = ~p;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R12 A rdata holds", a_rdata, p);
      check("R12 C rdata holds", c_rdata, bswap(p));
      pins = p;
      repeat (3) @(posedge clk);
      @(negedge clk);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule